// File: doc/BRIEF.md
# Exclusive Reservation Monitor with Event Mailbox

This block keeps the reservation for one core's load-exclusive / store-exclusive pairs. A load-exclusive arms the reservation and records the full physical address. A later store-exclusive is allowed to reach memory only if the reservation is still armed and both addresses fall in the same cache-block granule. A store-exclusive marked as a swap goes to memory without consulting or changing the monitor.

Three outside paths can break a reservation: a snoop (an invalidation or a write) whose block matches the reserved block, a local snoop-hit strobe, and a global clear-exclusive strobe. Each of them also posts an event into a one-bit mailbox, which a core sleeping in wait-for-event uses to resume. The snoop and global-clear paths also issue a one-cycle wakeup pulse. A wait-for-event consume input empties the mailbox.

The reservation is a two-state machine, `LK_OPEN` and `LK_HELD`. Transition `ARM` goes from `LK_OPEN` or `LK_HELD` to `LK_HELD` on a load-exclusive. Transition `DROP` goes from either state to `LK_OPEN` on any clearing cause. The mailbox is a second machine, `EV_EMPTY` and `EV_POSTED`. Transition `POST` moves it to `EV_POSTED` on any event. Transition `CONSUME` moves it from `EV_POSTED` to `EV_EMPTY`.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is open, `event_flag` is 0 and `wake_pulse` is 0.
- R2: A load-exclusive arms the reservation in the next cycle and records the whole address. A later store-exclusive to any byte in the same granule (default 64 bytes, given by parameter `BLK_BYTES`) then succeeds.
- R3: A snoop that arrives while the reservation is open changes nothing. It posts no event and causes no wakeup.
- R4: A snoop is compared at the granule on both sides: the stored address and the snoop address are each masked. On a match, the reservation opens, `event_flag` is 1 from the next cycle, and `wake_pulse` is 1 for exactly the next cycle.
- R5: `snp_hit_local` opens the reservation and sets `event_flag` from the next cycle. It does not raise `wake_pulse`.
- R6: `clrex` opens the reservation, sets `event_flag` and raises `wake_pulse`, each in the next cycle.
- R7: A store-exclusive with `stx_swap`=1 gives `stx_pass`=1 and `stx_fwd`=1 in the same cycle, and leaves the reservation unchanged.
- R8: A non-swap store-exclusive fails when the reservation is open or the granules differ. On failure `stx_pass`=0 and `stx_fwd`=0 in that cycle, and the reservation is open from the next cycle.
- R9: A non-swap store-exclusive that matches an armed reservation gives `stx_pass`=1 and `stx_fwd`=1 in that cycle, and the reservation is open from the next cycle.
- R10: If a load-exclusive coincides with any clearing cause (snoop match, local hit, clear-exclusive, non-swap store-exclusive), the reservation ends open.
- R11: `wfe_consume` empties the mailbox in the next cycle, unless an event is posted in the same cycle, in which case `event_flag` stays 1.
- R12: When `snp_valid`=1, `snp_kind` must be 2'b01 (invalidate) or 2'b10 (write). Any other code is an illegal input.
- R13: `stx_pass` and `stx_fwd` are 0 in any cycle without `stx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_valid | input | 1 | Load-exclusive request |
| ldx_addr | input | AW | Load-exclusive physical address |
| stx_valid | input | 1 | Store-exclusive request |
| stx_addr | input | AW | Store-exclusive physical address |
| stx_swap | input | 1 | Store is a swap; bypasses the monitor |
| snp_valid | input | 1 | Snoop transaction present |
| snp_kind | input | 2 | 01 invalidate, 10 write |
| snp_addr | input | AW | Snoop address (any byte alignment) |
| snp_hit_local | input | 1 | Local snoop-hit strobe |
| clrex | input | 1 | Global clear-exclusive strobe |
| wfe_consume | input | 1 | Wait-for-event consumes the mailbox |
| stx_pass | output | 1 | Store-exclusive result (1 = success) |
| stx_fwd | output | 1 | Forward the store to memory |
| event_flag | output | 1 | Event mailbox bit |
| wake_pulse | output | 1 | One-cycle core wakeup |

## Verification
Store-exclusives are aimed at the same byte, at another byte in the same granule, and at a different granule. These cases separate a granule compare from a full-address compare and from a missing compare. Snoops arrive both armed and unarmed, and with unaligned addresses. This shows whether both sides of the compare are masked, and whether the lock flag gates the snoop path. The three clearing strobes are driven alone and together with load-exclusives and consumes, which tells the local hit (no wakeup) apart from the waking paths and checks the same-cycle priorities. Seeded random traffic over a small pool of blocks mixes all of these against a bench model.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [1:0] {
        SNP_INVAL = 2'b01,
        SNP_WRITE = 2'b10
    } snp_kind_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef enum logic {
        EV_EMPTY  = 1'b0,
        EV_POSTED = 1'b1
    } event_state_e;

endpackage

// File: rtl/excl_granule_cmp.sv
module excl_granule_cmp #(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output logic          same_blk
);
    localparam logic [AW-1:0] OFS_BITS = AW'(BLK_BYTES - 1);
    localparam logic [AW-1:0] BLK_MASK = ~OFS_BITS;

    // Both operands are masked; neither side is assumed aligned.
    always_comb begin
        same_blk = ((addr_a & BLK_MASK) == (addr_b & BLK_MASK));
    end
endmodule

// File: rtl/excl_resv_fsm.sv
module excl_resv_fsm
    import excl_mon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic          drop,
    output logic          held,
    output logic [AW-1:0] lock_addr
);
    lock_state_e state_q, state_d;
    logic [AW-1:0] addr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arm) addr_q <= arm_addr;
        end
    end

    // transitions: DROP has priority over ARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (!drop && arm) state_d = LK_HELD;
            LK_HELD: if (drop)         state_d = LK_OPEN;
            default:                   state_d = LK_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        held      = (state_q == LK_HELD);
        lock_addr = addr_q;
    end

    p_drop_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !held);
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !drop) |=> held);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !drop) |=> $stable(held));
endmodule

// File: rtl/excl_event_box.sv
module excl_event_box
    import excl_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post_evt,
    input  logic post_wake,
    input  logic consume,
    output logic event_flag,
    output logic wake_pulse
);
    event_state_e ev_q, ev_d;
    logic wake_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q   <= EV_EMPTY;
            wake_q <= 1'b0;
        end else begin
            ev_q   <= ev_d;
            wake_q <= post_wake;
        end
    end

    // transitions: POST beats CONSUME
    always_comb begin
        ev_d = ev_q;
        unique case (ev_q)
            EV_EMPTY:  if (post_evt)              ev_d = EV_POSTED;
            EV_POSTED: if (consume && !post_evt)  ev_d = EV_EMPTY;
            default:                              ev_d = EV_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        event_flag = (ev_q == EV_POSTED);
        wake_pulse = wake_q;
    end

    p_post_sticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        post_evt |=> event_flag);
    p_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !post_evt) |=> !event_flag);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ldx_valid,
    input  logic [AW-1:0] ldx_addr,
    input  logic          stx_valid,
    input  logic [AW-1:0] stx_addr,
    input  logic          stx_swap,
    input  logic          snp_valid,
    input  logic [1:0]    snp_kind,
    input  logic [AW-1:0] snp_addr,
    input  logic          snp_hit_local,
    input  logic          clrex,
    input  logic          wfe_consume,
    output logic          stx_pass,
    output logic          stx_fwd,
    output logic          event_flag,
    output logic          wake_pulse
);
    logic          lock_held;
    logic [AW-1:0] lock_addr;
    logic          snp_same, stx_same;
    logic          snp_match, stx_excl, stx_ok;
    logic          drop, post_evt, post_wake;

    excl_granule_cmp #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_snp_cmp (
        .addr_a(lock_addr), .addr_b(snp_addr), .same_blk(snp_same));

    excl_granule_cmp #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_stx_cmp (
        .addr_a(lock_addr), .addr_b(stx_addr), .same_blk(stx_same));

    always_comb begin
        snp_match = snp_valid && lock_held && snp_same;
        stx_excl  = stx_valid && !stx_swap;
        stx_ok    = stx_excl && lock_held && stx_same;
        stx_pass  = (stx_valid && stx_swap) || stx_ok;
        stx_fwd   = stx_pass;
        drop      = snp_match || snp_hit_local || clrex || stx_excl;
        post_evt  = snp_match || snp_hit_local || clrex;
        post_wake = snp_match || clrex;
    end

    excl_resv_fsm #(.AW(AW)) u_resv (
        .clk(clk), .rst_n(rst_n),
        .arm(ldx_valid), .arm_addr(ldx_addr), .drop(drop),
        .held(lock_held), .lock_addr(lock_addr));

    excl_event_box u_evt (
        .clk(clk), .rst_n(rst_n),
        .post_evt(post_evt), .post_wake(post_wake), .consume(wfe_consume),
        .event_flag(event_flag), .wake_pulse(wake_pulse));

    p_snp_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (snp_kind == SNP_INVAL || snp_kind == SNP_WRITE));
    p_unarmed_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !lock_held && !clrex) |=> !wake_pulse);
    p_local_no_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit_local && !snp_match && !clrex) |=> (!wake_pulse && event_flag && !lock_held));
    p_clrex_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clrex |=> (wake_pulse && event_flag && !lock_held));
    p_snoop_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_match |=> (wake_pulse && event_flag && !lock_held));
    p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_valid && stx_swap) |-> (stx_pass && stx_fwd));
    p_fail_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_valid && !stx_swap && !lock_held) |-> (!stx_pass && !stx_fwd));
    p_pass_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_valid && !stx_swap && stx_fwd) |=> !lock_held);
    p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !stx_valid |-> (!stx_pass && !stx_fwd));
endmodule

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
    localparam int AW = 32;
    localparam int BLK_BYTES = 64;
    localparam logic [AW-1:0] MASK = ~AW'(BLK_BYTES - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ldx_valid, stx_valid, stx_swap, snp_valid, snp_hit_local, clrex, wfe_consume;
    logic [AW-1:0] ldx_addr, stx_addr, snp_addr;
    logic [1:0] snp_kind;
    logic stx_pass, stx_fwd, event_flag, wake_pulse;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model
    bit m_held, m_evt, m_wake;
    logic [AW-1:0] m_addr;

    always #4 clk = ~clk;

    excl_monitor #(.AW(AW), .BLK_BYTES(BLK_BYTES)) dut (
        .clk(clk), .rst_n(rst_n),
        .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
        .stx_valid(stx_valid), .stx_addr(stx_addr), .stx_swap(stx_swap),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .snp_hit_local(snp_hit_local), .clrex(clrex), .wfe_consume(wfe_consume),
        .stx_pass(stx_pass), .stx_fwd(stx_fwd),
        .event_flag(event_flag), .wake_pulse(wake_pulse));

    function automatic bit same_blk(logic [AW-1:0] a, logic [AW-1:0] b);
        return (a & MASK) == (b & MASK);
    endfunction

    function automatic bit exp_pass();
        if (!stx_valid) return 0;
        if (stx_swap) return 1;
        return m_held && same_blk(m_addr, stx_addr);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_in();
        ldx_valid = 0; ldx_addr = '0; stx_valid = 0; stx_addr = '0; stx_swap = 0;
        snp_valid = 0; snp_kind = 2'b01; snp_addr = '0;
        snp_hit_local = 0; clrex = 0; wfe_consume = 0;
    endtask

    function automatic string stx_tag();
        if (!stx_valid) return "R13";
        if (stx_swap) return "R7";
        if (m_held && same_blk(m_addr, stx_addr)) return "R9";
        return "R8";
    endfunction

    // Inputs are already driven; check same-cycle outputs, then advance model.
    task automatic finish_cycle(string evt_tag);
        bit snp_m, drop, post, wake;
        #1;
        chk(stx_tag(), stx_pass, exp_pass());
        chk(stx_tag(), stx_fwd, exp_pass());
        snp_m = snp_valid && m_held && same_blk(m_addr, snp_addr);
        drop  = snp_m || snp_hit_local || clrex || (stx_valid && !stx_swap);
        post  = snp_m || snp_hit_local || clrex;
        wake  = snp_m || clrex;
        if (ldx_valid) m_addr = ldx_addr;
        m_held = drop ? 0 : (ldx_valid ? 1 : m_held);
        m_evt  = post ? 1 : (wfe_consume ? 0 : m_evt);
        m_wake = wake;
        @(negedge clk);
        chk(evt_tag, event_flag, m_evt);
        chk((evt_tag == "R5") ? "R5" : "R4", wake_pulse, m_wake);
    endtask

    task automatic run(string evt_tag);
        finish_cycle(evt_tag);
        idle_in();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_in();
        m_held = 0; m_evt = 0; m_wake = 0; m_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state: open reservation shows as a failing store
        chk("R1", event_flag, 0);
        chk("R1", wake_pulse, 0);
        stx_valid = 1; stx_addr = 32'h0; #1;
        chk("R1", stx_pass, 0);
        run("R1");

        // R2 / R9: arm, store to other byte of same granule passes
        ldx_valid = 1; ldx_addr = 32'h0000_1007; run("R11");
        stx_valid = 1; stx_addr = 32'h0000_103C; run("R11");
        // R8: lock is now open (cleared by success) so a repeat fails
        stx_valid = 1; stx_addr = 32'h0000_1007; run("R11");
        // R8: different granule fails and opens lock
        ldx_valid = 1; ldx_addr = 32'h0000_2000; run("R11");
        stx_valid = 1; stx_addr = 32'h0000_2040; run("R11");
        stx_valid = 1; stx_addr = 32'h0000_2000; run("R11");

        // R3: snoop with open lock ignored
        snp_valid = 1; snp_kind = 2'b10; snp_addr = 32'h0000_2000; run("R3");
        chk("R3", event_flag, 0);

        // R4: unaligned snoop matching armed block
        ldx_valid = 1; ldx_addr = 32'h0000_3004; run("R4");
        snp_valid = 1; snp_kind = 2'b01; snp_addr = 32'h0000_3031; run("R4");
        chk("R4", wake_pulse, 1);
        stx_valid = 1; stx_addr = 32'h0000_3004; run("R4");
        chk("R4", wake_pulse, 0);

        // R11: consume empties mailbox
        wfe_consume = 1; run("R11");
        chk("R11", event_flag, 0);

        // R5: local hit, no wake
        ldx_valid = 1; ldx_addr = 32'h0000_4000; run("R5");
        snp_hit_local = 1; run("R5");
        chk("R5", wake_pulse, 0);
        chk("R5", event_flag, 1);
        stx_valid = 1; stx_addr = 32'h0000_4000; run("R5");

        // R6: global clear, combined with consume (R11 post wins)
        ldx_valid = 1; ldx_addr = 32'h0000_5000; run("R6");
        clrex = 1; wfe_consume = 1; run("R6");
        chk("R6", wake_pulse, 1);
        chk("R11", event_flag, 1);
        stx_valid = 1; stx_addr = 32'h0000_5000; run("R6");

        // R7: swap passes and leaves reservation armed
        wfe_consume = 1; run("R11");
        ldx_valid = 1; ldx_addr = 32'h0000_6000; run("R7");
        stx_valid = 1; stx_swap = 1; stx_addr = 32'h0000_9000; run("R7");
        stx_valid = 1; stx_addr = 32'h0000_6010; run("R7");

        // R10: load-exclusive together with clear-exclusive stays open
        ldx_valid = 1; ldx_addr = 32'h0000_7000; clrex = 1; run("R10");
        stx_valid = 1; stx_addr = 32'h0000_7000; run("R10");
        ldx_valid = 1; ldx_addr = 32'h0000_7000; stx_valid = 1; stx_addr = 32'h0000_7000; run("R10");
        stx_valid = 1; stx_addr = 32'h0000_7000; run("R10");

        // random traffic over four blocks
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] base;
            base = 32'h0001_0000 + (($urandom % 4) << 6);
            ldx_valid = ($urandom % 4) == 0;
            ldx_addr = base | ($urandom % 64);
            stx_valid = ($urandom % 3) == 0;
            stx_swap = ($urandom % 6) == 0;
            stx_addr = (32'h0001_0000 + (($urandom % 4) << 6)) | ($urandom % 64);
            snp_valid = ($urandom % 6) == 0;
            snp_kind = ($urandom % 2) ? 2'b01 : 2'b10;
            snp_addr = (32'h0001_0000 + (($urandom % 4) << 6)) | ($urandom % 64);
            snp_hit_local = ($urandom % 20) == 0;
            clrex = ($urandom % 20) == 0;
            wfe_consume = ($urandom % 5) == 0;
            run("R11");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule